// File: doc/BRIEF.md
# Single-Clock FIFO with Rejected-Access Reporting

This block is a first-in first-out buffer in one clock domain, built on an inferred two-port memory. A producer pushes words with a write strobe and a consumer pulls them with a read strobe. The read data is held in an output register. A word reaches the output only after a read has been requested, so the consumer always pulls data explicitly and nothing falls through on its own.

Four level flags are derived directly from the registered occupancy: full, empty, near-full and near-empty. Each flag takes its new value in the same cycle that the new occupancy becomes visible, with no extra pipeline stage. The near-full and near-empty margins are parameters.

A write issued while the buffer is full, or a read issued while it is empty, is refused. The refused access leaves the stored words, the pointers and the output register unchanged, and it raises a one-cycle error pulse. Both memory pointers are brought out for use by surrounding logic.

Top module: `guarded_fifo`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, empty_o=1, full_o=0, almost_empty_o=1, almost_full_o=0, wr_err_o=0, rd_err_o=0, rd_data_o=0, and wr_addr_o and rd_addr_o are both 0.
- R2: Words leave in the order they were accepted, with no loss and no duplication.
- R3: rd_data_o changes only in the cycle after an accepted read, when it takes the oldest stored word. A word written into an empty buffer does not appear on rd_data_o until it is read.
- R4: full_o is high exactly when DEPTH words are stored. A write request while full_o is high stores nothing, leaves wr_addr_o unchanged, and sets wr_err_o high for the following cycle only.
- R5: A read request while empty_o is high leaves rd_data_o and rd_addr_o unchanged, and sets rd_err_o high for the following cycle only.
- R6: empty_o is high exactly when no word is stored. After the first accepted write into an empty buffer, empty_o is low in the next cycle.
- R7: almost_full_o is high exactly when occupancy is at least DEPTH-AF_MARGIN.
- R8: almost_empty_o is high exactly when occupancy is at most AE_MARGIN.
- R9: A read and a write in the same cycle on a buffer that is neither empty nor full are both accepted, and the occupancy and all four level flags stay unchanged.
- R10: A read and a write in the same cycle on a full buffer accept the read, refuse the write with wr_err_o, and leave the buffer not full.
- R11: wr_addr_o advances by one, modulo DEPTH, per accepted write, and rd_addr_o advances by one, modulo DEPTH, per accepted read. Refused accesses leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | WIDTH | Registered read word |
| full_o | output | 1 | DEPTH words stored |
| empty_o | output | 1 | No word stored |
| almost_full_o | output | 1 | Occupancy at or above DEPTH-AF_MARGIN |
| almost_empty_o | output | 1 | Occupancy at or below AE_MARGIN |
| wr_err_o | output | 1 | Pulse after a refused write |
| rd_err_o | output | 1 | Pulse after a refused read |
| wr_addr_o | output | AW | Write pointer |
| rd_addr_o | output | AW | Read pointer |

## Verification
The bound checker watches several rules on every cycle: refused accesses raise their error pulses and freeze the pointers and the read register, rd_data_o stays stable without a read, the pointers step by one, a write into an empty buffer clears empty_o, a balanced access leaves every level flag unchanged, and each error pulse has a matching cause. The assertions cannot show data ordering or the exact occupancy at which the near-full and near-empty flags switch. The bench shows these by comparing every output, on every cycle, against a queue model driven through fill, drain, overflow, underflow and simultaneous-access scenarios.

// File: rtl/guarded_fifo_pkg.sv
package guarded_fifo_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic afull;
    logic aempty;
  } gf_lvl_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_BOTH = 2'b11
  } gf_op_e;

endpackage

// File: rtl/gf_ptr.sv
module gf_ptr #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  localparam bit POW2 = (DEPTH == (1 << AW));
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_nxt;

  generate
    if (POW2) begin : g_pow2
      assign ptr_nxt = ptr_q + 1'b1;  // natural wrap
    end else begin : g_mod
      assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/gf_mem.sv
module gf_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // storage carries no reset so it maps to RAM
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gf_level.sv
module gf_level
  import guarded_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CW        = 5,
  parameter int AF_MARGIN = 2,
  parameter int AE_MARGIN = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_req_i,
  input  logic    rd_req_i,
  output logic    wr_ok_o,
  output logic    rd_ok_o,
  output gf_lvl_t lvl_o,
  output logic    wr_err_o,
  output logic    rd_err_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] AF_LVL   = CW'(DEPTH - AF_MARGIN);
  localparam logic [CW-1:0] AE_LVL   = CW'(AE_MARGIN);

  logic [CW-1:0] cnt_q;
  logic          wr_err_q, rd_err_q;
  gf_op_e        op;

  assign lvl_o.full   = (cnt_q == FULL_LVL);
  assign lvl_o.empty  = (cnt_q == '0);
  assign lvl_o.afull  = (cnt_q >= AF_LVL);
  assign lvl_o.aempty = (cnt_q <= AE_LVL);

  assign wr_ok_o = wr_req_i & ~lvl_o.full;
  assign rd_ok_o = rd_req_i & ~lvl_o.empty;
  assign op      = gf_op_e'({wr_ok_o, rd_ok_o});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_err_q <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      wr_err_q <= wr_req_i & lvl_o.full;
      rd_err_q <= rd_req_i & lvl_o.empty;
      unique case (op)
        OP_WR:   cnt_q <= cnt_q + 1'b1;
        OP_RD:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_err_o = wr_err_q;
  assign rd_err_o = rd_err_q;
endmodule

// File: rtl/guarded_fifo.sv
module guarded_fifo
  import guarded_fifo_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 16,
  parameter int AF_MARGIN = 2,
  parameter int AE_MARGIN = 2,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             almost_full_o,
  output logic             almost_empty_o,
  output logic             wr_err_o,
  output logic             rd_err_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [AW-1:0]    rd_addr_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic    wr_ok, rd_ok;
  gf_lvl_t lvl;

  gf_level #(
    .DEPTH(DEPTH), .CW(CW), .AF_MARGIN(AF_MARGIN), .AE_MARGIN(AE_MARGIN)
  ) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_req_i(wr_en_i),
    .rd_req_i(rd_en_i),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok),
    .lvl_o   (lvl),
    .wr_err_o(wr_err_o),
    .rd_err_o(rd_err_o)
  );

  gf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_ok), .ptr_o(wr_addr_o)
  );

  gf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_ok), .ptr_o(rd_addr_o)
  );

  gf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok),
    .waddr_i(wr_addr_o),
    .wdata_i(wr_data_i),
    .re_i   (rd_ok),
    .raddr_i(rd_addr_o),
    .rdata_o(rd_data_o)
  );

  assign full_o         = lvl.full;
  assign empty_o        = lvl.empty;
  assign almost_full_o  = lvl.afull;
  assign almost_empty_o = lvl.aempty;
endmodule

// File: rtl/guarded_fifo_chk.sv
module guarded_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             almost_full_o,
  input logic             almost_empty_o,
  input logic             wr_err_o,
  input logic             rd_err_o,
  input logic [AW-1:0]    wr_addr_o,
  input logic [AW-1:0]    rd_addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R4
  wr_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> (wr_err_o && wr_addr_o == $past(wr_addr_o)));

  // R5
  rd_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=>
      (rd_err_o && rd_addr_o == $past(rd_addr_o) && rd_data_o == $past(rd_data_o)));

  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R11
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !full_o) |=>
      (wr_addr_o == (($past(wr_addr_o) == LAST) ? '0 : $past(wr_addr_o) + 1'b1)));

  // R11
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_o) |=>
      (rd_addr_o == (($past(rd_addr_o) == LAST) ? '0 : $past(rd_addr_o) + 1'b1)));

  // R6
  empty_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_en_i) |=> !empty_o);

  // R9
  balanced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && !full_o && !empty_o) |=>
      ($stable(full_o) && $stable(empty_o) && $stable(almost_full_o) && $stable(almost_empty_o)));

  // R10
  full_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && full_o) |=> (!full_o && wr_err_o));

  // R4
  wr_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i && full_o));

  // R5
  rd_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> $past(rd_en_i && empty_o));

  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R7
  full_afull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o);

  // R8
  empty_aempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o);
endmodule

bind guarded_fifo guarded_fifo_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .rd_data_o     (rd_data_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .almost_full_o (almost_full_o),
  .almost_empty_o(almost_empty_o),
  .wr_err_o      (wr_err_o),
  .rd_err_o      (rd_err_o),
  .wr_addr_o     (wr_addr_o),
  .rd_addr_o     (rd_addr_o)
);

// File: tb/guarded_fifo_tb_top.sv
module guarded_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int AF_M  = 2;
  localparam int AE_M  = 2;
  localparam int AW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             full, empty, afull, aempty, wr_err, rd_err;
  logic [AW-1:0]    wr_addr, rd_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model
  logic [WIDTH-1:0] q [$];
  logic [WIDTH-1:0] exp_rd = '0;
  int exp_wa = 0;
  int exp_ra = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  guarded_fifo #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .AF_MARGIN(AF_M), .AE_MARGIN(AE_M)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .full_o(full), .empty_o(empty),
    .almost_full_o(afull), .almost_empty_o(aempty),
    .wr_err_o(wr_err), .rd_err_o(rd_err),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = q.size();
    chk("R4 full", full, n == DEPTH);
    chk("R6 empty", empty, n == 0);
    chk("R7 almost_full", afull, n >= DEPTH - AF_M);
    chk("R8 almost_empty", aempty, n <= AE_M);
    chk("R2 rd_data", rd_data, exp_rd);
    chk("R11 wr_addr", wr_addr, exp_wa);
    chk("R11 rd_addr", rd_addr, exp_ra);
  endtask

  // one clock: drive, model, sample 1 time unit after the edge
  task automatic cyc(input bit we, input logic [WIDTH-1:0] wd, input bit re);
    int  n = q.size();
    bit  e_werr = we && (n == DEPTH);
    bit  e_rerr = re && (n == 0);
    wr_en = we; wr_data = wd; rd_en = re;
    if (re && n > 0) begin
      exp_rd = q.pop_front();
      exp_ra = (exp_ra + 1) % DEPTH;
    end
    if (we && n < DEPTH) begin
      q.push_back(wd);
      exp_wa = (exp_wa + 1) % DEPTH;
    end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R4 wr_err", wr_err, e_werr);
    chk("R5 rd_err", rd_err, e_rerr);
    compare_all();
  endtask

  task automatic t_reset();
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    chk("R1 aempty in reset", aempty, 1);
    chk("R1 afull in reset", afull, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 wr_err", wr_err, 0);
    chk("R1 rd_err", rd_err, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 rd_addr", rd_addr, 0);
    compare_all();
  endtask

  task automatic t_underflow();
    logic [WIDTH-1:0] held = rd_data;
    logic [AW-1:0]    ra = rd_addr;
    cyc(1'b0, '0, 1'b1);
    chk("R5 rd_err pulse", rd_err, 1);
    chk("R5 rd_data held", rd_data, held);
    chk("R5 rd_addr held", rd_addr, ra);
    cyc(1'b0, '0, 1'b0);
    chk("R5 rd_err single cycle", rd_err, 0);
  endtask

  task automatic t_standard_mode();
    logic [WIDTH-1:0] held = rd_data;
    cyc(1'b1, 8'hA5, 1'b0);
    chk("R6 empty clears", empty, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, '0, 1'b0);
      chk("R3 no fall-through", rd_data, held);
    end
    cyc(1'b0, '0, 1'b1);
    chk("R3 word after read", rd_data, 8'hA5);
    chk("R6 empty again", empty, 1);
  endtask

  task automatic t_fill_overflow();
    logic [AW-1:0] wa;
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, WIDTH'(i * 7 + 3), 1'b0);
    chk("R4 full after DEPTH writes", full, 1);
    wa = wr_addr;
    cyc(1'b1, 8'hEE, 1'b0);
    chk("R4 wr_err pulse", wr_err, 1);
    chk("R4 wr_addr held", wr_addr, wa);
    cyc(1'b0, '0, 1'b0);
    chk("R4 wr_err single cycle", wr_err, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R2 order after overflow", rd_data, WIDTH'(i * 7 + 3));
    end
    chk("R6 empty after drain", empty, 1);
  endtask

  task automatic t_balanced();
    for (int i = 0; i < 5; i++) cyc(1'b1, WIDTH'(8'h40 + i), 1'b0);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, WIDTH'(8'h80 + i), 1'b1);
      chk("R9 occupancy kept", q.size(), 5);
      chk("R9 not empty", empty, 0);
      chk("R9 not full", full, 0);
    end
    while (q.size() > 0) cyc(1'b0, '0, 1'b1);
  endtask

  task automatic t_full_both();
    logic [WIDTH-1:0] head;
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, WIDTH'(8'hC0 + i), 1'b0);
    head = q[0];
    cyc(1'b1, 8'h11, 1'b1);
    chk("R10 wr_err on full", wr_err, 1);
    chk("R10 read accepted", rd_data, head);
    chk("R10 no longer full", full, 0);
    while (q.size() > 0) cyc(1'b0, '0, 1'b1);
    chk("R10 dropped word absent", exp_rd, 8'hCF);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_underflow();
    t_standard_mode();
    t_fill_overflow();
    t_balanced();
    t_full_both();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule